// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a serial slave on a two-wire (I2C-style) bus. Through it a host reads and writes a bank of up to 128 byte-wide registers. The two bus lines are brought into the system clock domain, where START and STOP conditions and SCL edges are detected. A header byte is matched against a 7-bit device address that comes from strap inputs. After a write-addressed header, the next byte loads an internal register pointer. Every byte after that is written to the register bank through a plain parallel port: an address output, write data, a one-cycle write strobe, and a read-data input that the bank answers combinationally.

The top bit of the pointer byte decides what happens between bytes. When the bit is clear, the pointer advances after each byte. When it is set, the pointer stays on one register. A STOP always returns the pointer to register 0. A read that opens with a read-addressed header straight after START therefore streams from register 0. To read from any other register, the host first writes the pointer byte and then issues a repeated START with a read header. A mask parameter marks some registers as read-only. Writes to those registers are dropped without notice, and the pointer still moves on as usual.

Top module: `twi_regslave`

## Requirements
- R1: A header byte is acknowledged only when its bits 7:1 equal the strap value on `dev_addr_i`. When it does not match, the slave leaves SDA released for the acknowledge slot and for every later bit until the next START, and it performs no register access.
- R2: After a matching header with bit 0 = 0, the next byte sets the pointer from its bits 6:0. Each further byte is written with one `reg_we` pulse that carries the pointer address and the received byte, sent most significant bit first.
- R3: When bit 7 of the pointer byte is 1, every byte (written or read) uses the same register. When bit 7 is 0, the pointer advances by one after each data byte.
- R4: When the pointer advances from 127, it wraps to 0.
- R5: After reset, and after any STOP, the pointer is 0 and the inhibit flag is clear.
- R6: A read-addressed header (bit 0 = 1) with no address phase since the last STOP returns register 0 first, then the registers that follow it.
- R7: A repeated START with a read header after a pointer byte returns data from the selected register onward. Bytes are sent most significant bit first.
- R8: A write to a register flagged in `RO_MASK` (by default only register 107) causes no `reg_we` pulse, but the pointer still advances.
- R9: The slave drives an acknowledge after its matching header and after every byte it receives. During a read it releases SDA in the host's acknowledge slot. A host NACK ends the read, and SDA stays released afterwards.
- R10: A START detected at any point, including in the middle of a byte, restarts header reception with a cleared bit counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| dev_addr_i | input | 7 | Strapped device address |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it (open drain) |
| reg_addr | output | 7 | Register pointer, used as the bank address |
| reg_wdata | output | 8 | Byte to write to the bank |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Bank contents at `reg_addr` |

## Verification
On every cycle the assertions check the pointer rules: clearing on STOP, a step of one or a hold after each data byte, and the wrap at the top of the range. They also check that no write strobe reaches a read-only register, that a write strobe occurs only on an SCL rising edge, that header reception restarts on START, and that SDA stays released while idle. Address matching, the byte values written and read back, acknowledge placement on the wire, and the three ways a read can begin (after STOP, after a pointer byte, with the pointer held) can only be shown by the bench's bus transactions. The bench checks these against its own model of the register bank and the pointer.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int TWI_BYTE_W = 8;
  localparam int TWI_DEV_W  = 7;
  localparam int TWI_PTR_W  = 7;
  localparam int TWI_NREG   = 1 << TWI_PTR_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_RADDR, ST_WDATA, ST_ACK, ST_RDATA, ST_MACK
  } twi_st_e;

  // next pointer value after a data byte
  function automatic logic [TWI_PTR_W-1:0] ptr_step(input logic [TWI_PTR_W-1:0] p,
                                                    input logic hold);
    return hold ? p : p + TWI_PTR_W'(1);
  endfunction

  // header byte: device address in bits 7:1, direction in bit 0
  function automatic logic hdr_match(input logic [TWI_BYTE_W-1:0] hb,
                                     input logic [TWI_DEV_W-1:0] dev);
    return hb[TWI_BYTE_W-1:1] == dev;
  endfunction
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;
  logic scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_reg_ptr.sv
module twi_reg_ptr
  import twi_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  load,
  input  logic [TWI_BYTE_W-1:0] load_byte,
  input  logic                  step,
  output logic [TWI_PTR_W-1:0]  ptr,
  output logic                  hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      hold <= 1'b0;
    end else if (clr) begin
      ptr  <= '0;
      hold <= 1'b0;
    end else if (load) begin
      ptr  <= load_byte[TWI_PTR_W-1:0];
      hold <= load_byte[TWI_BYTE_W-1];
    end else if (step) begin
      ptr  <= ptr_step(ptr, hold);
    end
  end
endmodule

// File: rtl/twi_regslave.sv
module twi_regslave
  import twi_pkg::*;
#(
  parameter int                  SYNC_STAGES = 2,
  parameter logic [TWI_NREG-1:0] RO_MASK     = TWI_NREG'(1) << 107
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [TWI_DEV_W-1:0]  dev_addr_i,
  output logic                  sda_drive_low,
  output logic [TWI_PTR_W-1:0]  reg_addr,
  output logic [TWI_BYTE_W-1:0] reg_wdata,
  output logic                  reg_we,
  input  logic [TWI_BYTE_W-1:0] reg_rdata
);
  localparam int BC_W = $clog2(TWI_BYTE_W);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(TWI_BYTE_W - 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  twi_st_e state, ack_next;
  logic [BC_W-1:0] bitcnt;
  logic [TWI_BYTE_W-1:0] shreg;
  logic ack_drv, tx_en, mack_seen, mack_ok;
  logic [TWI_PTR_W-1:0] ptr;
  logic ptr_hold;

  // named internal events
  logic [TWI_BYTE_W-1:0] rx_byte;
  logic last_bit, rx_state, byte_done_rx, raddr_done, wr_byte, rd_byte;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign rx_byte      = {shreg[TWI_BYTE_W-2:0], sda_s};
  assign last_bit     = bitcnt == BC_LAST;
  assign rx_state     = (state == ST_HDR) || (state == ST_RADDR) || (state == ST_WDATA);
  assign byte_done_rx = rx_state && scl_rise && last_bit;
  assign raddr_done   = byte_done_rx && (state == ST_RADDR);
  assign wr_byte      = byte_done_rx && (state == ST_WDATA);
  assign rd_byte      = (state == ST_RDATA) && scl_rise && last_bit;

  twi_reg_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(stop_det), .load(raddr_done),
    .load_byte(rx_byte), .step(wr_byte || rd_byte),
    .ptr(ptr), .hold(ptr_hold)
  );

  assign reg_addr      = ptr;
  assign reg_wdata     = rx_byte;
  assign reg_we        = wr_byte && !RO_MASK[ptr];
  assign sda_drive_low = ack_drv | (tx_en & ~shreg[TWI_BYTE_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ack_next  <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      ack_drv   <= 1'b0;
      tx_en     <= 1'b0;
      mack_seen <= 1'b0;
      mack_ok   <= 1'b0;
    end else if (start_det) begin
      state   <= ST_HDR;
      bitcnt  <= '0;
      ack_drv <= 1'b0;
      tx_en   <= 1'b0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      ack_drv <= 1'b0;
      tx_en   <= 1'b0;
    end else begin
      unique case (state)
        ST_HDR, ST_RADDR, ST_WDATA: begin
          if (scl_rise) begin
            shreg  <= rx_byte;
            bitcnt <= bitcnt + BC_W'(1);
            if (last_bit) begin
              if (state != ST_HDR) begin
                state    <= ST_ACK;
                ack_next <= ST_WDATA;
              end else if (hdr_match(rx_byte, dev_addr_i)) begin
                state    <= ST_ACK;
                ack_next <= rx_byte[0] ? ST_RDATA : ST_RADDR;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (!ack_drv) begin
              ack_drv <= 1'b1;
            end else begin
              ack_drv <= 1'b0;
              bitcnt  <= '0;
              state   <= ack_next;
              if (ack_next == ST_RDATA) begin
                shreg <= reg_rdata;
                tx_en <= 1'b1;
              end
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + BC_W'(1);
            if (last_bit) begin
              state     <= ST_MACK;
              mack_seen <= 1'b0;
            end
          end else if (scl_fall) begin
            shreg <= {shreg[TWI_BYTE_W-2:0], 1'b0};
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_seen <= 1'b1;
            mack_ok   <= ~sda_s;
          end else if (scl_fall) begin
            if (!mack_seen) begin
              tx_en <= 1'b0;
            end else if (mack_ok) begin
              shreg  <= reg_rdata;
              tx_en  <= 1'b1;
              bitcnt <= '0;
              state  <= ST_RDATA;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/twi_regslave_chk.sv
module twi_regslave_chk
  import twi_pkg::*;
#(
  parameter logic [TWI_NREG-1:0] RO_MASK = TWI_NREG'(1) << 107
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_det,
  input logic                 stop_det,
  input logic                 scl_rise,
  input logic                 wr_byte,
  input logic                 rd_byte,
  input logic                 reg_we,
  input logic [TWI_PTR_W-1:0] reg_addr,
  input logic                 ptr_hold,
  input twi_st_e              state,
  input logic [2:0]           bitcnt,
  input logic                 sda_drive_low
);
  assert_stop_clears_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (reg_addr == '0 && !ptr_hold));

  assert_ro_never_written_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !RO_MASK[reg_addr]);

  // also covers the wrap of R4: 127 + 1 folds to 0 in the pointer width
  assert_ptr_advances_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_byte || rd_byte) && !ptr_hold) |=> reg_addr == TWI_PTR_W'($past(reg_addr) + 1));

  assert_ptr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_byte || rd_byte) && ptr_hold) |=> $stable(reg_addr));

  assert_start_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_HDR && bitcnt == '0));

  assert_write_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> scl_rise);

  assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_drive_low);
endmodule

bind twi_regslave twi_regslave_chk #(.RO_MASK(RO_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
  .scl_rise(scl_rise), .wr_byte(wr_byte), .rd_byte(rd_byte), .reg_we(reg_we),
  .reg_addr(reg_addr), .ptr_hold(ptr_hold), .state(state), .bitcnt(bitcnt),
  .sda_drive_low(sda_drive_low)
);

// File: tb/tb_twi_regslave.sv
module tb_twi_regslave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam int WD_CYCLES = 150000;
  localparam logic [6:0] DEV = 7'h4A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_scl = 1'b1, host_sda = 1'b1;
  logic sda_drive_low, reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic sda_line;
  logic [7:0] bank [128];
  int mdl [128];
  int q_a[$], q_d[$];
  int mptr = 0;
  bit minh = 1'b0;
  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line  = host_sda & ~sda_drive_low;
  assign reg_rdata = bank[reg_addr];

  twi_regslave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line),
    .dev_addr_i(DEV), .sda_drive_low(sda_drive_low), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_ro(input int a);
    return a == 107;
  endfunction

  function automatic void m_step();
    if (!minh) mptr = (mptr + 1) % 128;
  endfunction

  initial begin
    for (int i = 0; i < 128; i++) begin
      bank[i] = 8'((i * 29 + 7) & 255);
      mdl[i]  = (i * 29 + 7) & 255;
    end
  end

  always_ff @(posedge clk) if (reg_we) bank[reg_addr] <= reg_wdata;

  // reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      chk(!is_ro(int'(reg_addr)), "R8", "strobe at read-only register", int'(reg_addr), 0);
      if (q_a.size() == 0) begin
        chk(1'b0, "R2", "unexpected write strobe", int'(reg_addr), -1);
      end else begin
        chk(int'(reg_addr) == q_a[0], "R2", "write address", int'(reg_addr), q_a[0]);
        chk(int'(reg_wdata) == q_d[0], "R2", "write data", int'(reg_wdata), q_d[0]);
        void'(q_a.pop_front());
        void'(q_d.pop_front());
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; wq(Q);
    host_scl = 1'b1; wq(Q);
    host_sda = 1'b0; wq(Q);
    host_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wq(Q);
    host_scl = 1'b1; wq(Q);
    host_sda = 1'b1; wq(Q);
    mptr = 0; minh = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      host_sda = b[i]; wq(Q);
      host_scl = 1'b1; wq(2 * Q);
      host_scl = 1'b0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    host_sda = 1'b1; wq(Q);
    host_scl = 1'b1; wq(Q);
    acked = !sda_line; wq(Q);
    host_scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      host_scl = 1'b1; wq(Q);
      b[i] = sda_line; wq(Q);
      host_scl = 1'b0;
    end
    host_sda = !give_ack; wq(Q);
    host_scl = 1'b1; wq(2 * Q);
    host_scl = 1'b0; wq(Q);
    host_sda = 1'b1;
  endtask

  // write header, pointer byte and n data bytes; no STOP
  task automatic t_write(input bit do_start, input int regbyte, input int n,
                         input int base, input string req);
    bit ack;
    if (do_start) bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk(ack, "R1", "ack of matching write header", ack, 1);
    send_byte(8'(regbyte), ack);
    chk(ack, "R9", "ack of pointer byte", ack, 1);
    mptr = regbyte & 127;
    minh = regbyte[7];
    for (int i = 0; i < n; i++) begin
      int d = (base + i * 17) & 255;
      if (!is_ro(mptr)) begin
        q_a.push_back(mptr);
        q_d.push_back(d);
        mdl[mptr] = d;
      end
      send_byte(8'(d), ack);
      chk(ack, "R9", "ack of data byte", ack, 1);
      m_step();
    end
    wq(2);
    chk(q_a.size() == 0, req, "pending expected writes", q_a.size(), 0);
  endtask

  // read header after START or repeated START, n bytes, last one NACKed
  task automatic t_read(input int n, input string req);
    bit ack;
    logic [7:0] b;
    send_byte({DEV, 1'b1}, ack);
    chk(ack, "R1", "ack of matching read header", ack, 1);
    for (int i = 0; i < n; i++) begin
      int e = mdl[mptr];
      recv_byte(i < n - 1, b);
      chk(int'(b) == e, req, "read data", int'(b), e);
      m_step();
    end
    wq(Q);
    chk(!sda_drive_low, "R9", "SDA released after host NACK", sda_drive_low, 0);
  endtask

  initial begin
    bit ack;
    wq(3);
    chk(!sda_drive_low, "R5", "reset SDA released", sda_drive_low, 0);
    chk(reg_addr == 7'd0, "R5", "reset pointer", int'(reg_addr), 0);
    chk(!reg_we, "R5", "reset write strobe", reg_we, 0);
    rst_n = 1'b1;
    wq(4);

    // R2 R3: incrementing write from register 5
    t_write(1'b1, 5, 3, 8'hA1, "R2");
    bus_stop();
    // R6: read with no address phase starts at 0
    bus_start(); t_read(3, "R6"); bus_stop();
    // R3 R7: inhibited write then repeated-START read stays on register 10
    t_write(1'b1, 8'h80 | 10, 2, 8'h30, "R3");
    bus_start(); t_read(2, "R3"); bus_stop();
    // R4 R7: read across the top of the range
    t_write(1'b1, 126, 0, 0, "R7");
    bus_start(); t_read(3, "R4"); bus_stop();
    // R8: write run through a read-only register, then read it back
    t_write(1'b1, 106, 3, 8'h55, "R8");
    bus_stop();
    t_write(1'b1, 106, 0, 0, "R8");
    bus_start(); t_read(3, "R8"); bus_stop();
    // R1: foreign address is ignored, including the bytes after it
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, ack);
    chk(!ack, "R1", "no ack for foreign header", ack, 0);
    send_byte(8'h22, ack);
    chk(!ack, "R1", "no ack after foreign header", ack, 0);
    bus_stop();
    wq(2);
    chk(q_a.size() == 0, "R1", "no write after foreign header", q_a.size(), 0);
    // R10: START in the middle of a header byte
    bus_start();
    send_bits({DEV, 1'b0}, 3);
    t_write(1'b1, 20, 1, 8'h77, "R10");
    bus_stop();
    // R5: STOP clears inhibit and pointer, so read goes 0 then 1
    t_write(1'b1, 8'h80 | 40, 1, 8'h11, "R5");
    bus_stop();
    bus_start(); t_read(2, "R5"); bus_stop();

    wq(10);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule